// File: doc/BRIEF.md
# Host RAM window decoder

This block lets a host read and write part of a local byte RAM through up to two address windows. Each window has a base address, a power-of-two length, and separate read and write protection codes. A protection code can cover the lower half of the window, the upper half, or all of it. A control register turns each window on and chooses whether the windows answer host I/O cycles or host memory cycles.

For every host access the block does four things:
- It decides which window, if any, claims the address. Window 0 wins when both windows claim it.
- It checks the protection for that access direction.
- If the access is allowed, it reads or writes the RAM at an offset equal to the host address.
- If the access is protected, it returns FFh for a read or drops the write, and raises a one-cycle violation flag.

A local port reaches the same RAM directly and always has priority. A host access that meets a local access waits until the local port is idle.

Top module: `hostram_window_dec`

## Requirements
- R1: After reset all configuration registers read 00h, `h_ack` and `h_viol` are low, and `h_rdata` and `l_rdata` are 00h.
- R2: Configuration map:
  - Address 0 is control: bit 0 enables window 0, bit 1 enables window 1, bit 4 set means the windows answer I/O cycles and clear means they answer memory cycles. The other control bits read 0.
  - Addresses 1 and 2 hold the base of window 0 and window 1, as host address bits [11:4].
  - Addresses 3 and 4 hold the attributes of window 0 and window 1: bits [7:6] read protection, bits [5:4] write protection, bits [2:0] size code.
  - Addresses 5 to 7 read 00h and ignore writes.
  - A register write takes effect at the clock edge where `cfg_we` is sampled high. `cfg_rdata` shows the addressed register combinationally.
- R3: Window n claims a host access only when all of these hold:
  - its enable bit is set;
  - `h_io` equals control bit 4;
  - the address lies in the 16<<size-byte block that starts at base×16 rounded down to a multiple of that length.
- R4: An allowed host access uses RAM location equal to the 12-bit host address, so host 900h maps to RAM 900h.
- R5: Protection code 00 blocks nothing, 01 blocks the lower half of the window, 10 blocks the upper half, and 11 blocks the whole window. The read code applies to reads and the write code applies to writes.
- R6: A blocked read returns FFh. A blocked write leaves the RAM unchanged. Either one sets `h_viol` high in its acknowledge cycle.
- R7: An access that no window claims is acknowledged with `h_rdata` FFh. It does not set `h_viol` and does not write the RAM.
- R8: When both windows claim an address, the protection of window 0 applies.
- R9: The block grants a host access at a clock edge where `h_req` is high, `l_req` is low and `h_ack` is low. After the grant:
  - `h_ack` is high for exactly the next cycle.
  - `h_rdata` then holds the read data, or FFh for a write, a miss or a block.
  - `h_rdata` keeps its value between acknowledges.
- R10: While `l_req` is high, no host access is granted. The host request waits and is granted at the first edge where `l_req` is low.
- R11: A local write stores `l_wdata` at `l_addr` at the clock edge. A local read presents the byte in `l_rdata` in the next cycle, and `l_rdata` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| h_req | input | 1 | Host access request, held until acknowledged |
| h_io | input | 1 | Host cycle type, 1 = I/O, 0 = memory |
| h_wr | input | 1 | Host write when high, read when low |
| h_addr | input | 12 | Host address |
| h_wdata | input | 8 | Host write data |
| h_ack | output | 1 | Host access done, one-cycle pulse |
| h_viol | output | 1 | Protection violation, pulses with `h_ack` |
| h_rdata | output | 8 | Host read data |
| l_req | input | 1 | Local RAM access request |
| l_wr | input | 1 | Local write when high |
| l_addr | input | 12 | Local RAM address |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data, one cycle after the request |

## Verification
The decoder is tested with several access patterns, and each one separates a different cause of failure:
- **Two-window setup with a write-protected second window.** Accesses at both window edges and just outside them separate a wrong hit range from a wrong offset.
- **Sweep of all sixteen read/write protection code pairs.** Each pair is probed in the lower and upper half, in both directions, and a local read-back follows each host write. This separates the half-select bit from the direction select.
- **Sweep of all eight size codes around an unaligned base.** This shows whether the low base bits are masked correctly.
- **Overlapping windows, cycle-type flipping and a held local request.** These separate window priority, the I/O-versus-memory match and the host stall.

// File: rtl/hostram_window_dec.sv
module hostram_window_dec #(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int NWIN        = 2,
  parameter int CTRL_IO_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          h_req,
  input  logic          h_io,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          h_ack,
  output logic          h_viol,
  output logic [DW-1:0] h_rdata,
  input  logic          l_req,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata
);

  localparam int BW    = AW - 4;
  localparam int IW    = $clog2(AW);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] CTRL_MASK = 8'(((1 << NWIN) - 1) | (1 << CTRL_IO_BIT));

  logic [7:0]    ctrl;
  logic [BW-1:0] base [NWIN];
  logic [7:0]    attr [NWIN];
  logic [DW-1:0] mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < NWIN; i++) begin
        base[i] <= '0;
        attr[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 3'd0) ctrl <= cfg_wdata & CTRL_MASK;
      for (int i = 0; i < NWIN; i++) begin
        if (cfg_addr == 3'(1 + i))        base[i] <= cfg_wdata[BW-1:0];
        if (cfg_addr == 3'(1 + NWIN + i)) attr[i] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 3'd0) cfg_rdata = ctrl;
    for (int i = 0; i < NWIN; i++) begin
      if (cfg_addr == 3'(1 + i))        cfg_rdata = 8'(base[i]);
      if (cfg_addr == 3'(1 + NWIN + i)) cfg_rdata = attr[i];
    end
  end

  logic [NWIN-1:0] hit, blk;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [2:0]    sz;
    logic [BW-1:0] msk;
    logic [IW-1:0] half_bit;
    logic [1:0]    code;
    logic          up;
    assign sz       = attr[i][2:0];
    assign msk      = BW'((1 << sz) - 1);
    assign half_bit = IW'(sz) + IW'(3);
    assign up       = h_addr[half_bit];
    assign code     = h_wr ? attr[i][5:4] : attr[i][7:6];
    assign hit[i]   = ctrl[i] && (h_io == ctrl[CTRL_IO_BIT]) &&
                      ((h_addr[AW-1:4] & ~msk) == (base[i] & ~msk));
    assign blk[i]   = (code == 2'b11) || (code == 2'b01 && !up) || (code == 2'b10 && up);
  end

  logic any_hit, sel_blk, grant, allow;

  always_comb begin
    sel_blk = 1'b0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) sel_blk = blk[i];
  end

  assign any_hit = |hit;
  assign grant   = h_req && !l_req && !h_ack;
  assign allow   = grant && any_hit && !sel_blk;

  always_ff @(posedge clk) begin
    if (l_req && l_wr)        mem[l_addr] <= l_wdata;
    else if (allow && h_wr)   mem[h_addr] <= h_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ack   <= 1'b0;
      h_viol  <= 1'b0;
      h_rdata <= '0;
      l_rdata <= '0;
    end else begin
      h_ack  <= grant;
      h_viol <= grant && any_hit && sel_blk;
      if (grant)             h_rdata <= (allow && !h_wr) ? mem[h_addr] : '1;
      if (l_req && !l_wr)    l_rdata <= mem[l_addr];
    end
  end

  assert_ack_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> !h_ack);
  assert_grant_acked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !l_req && !h_ack) |=> h_ack);
  assert_local_stalls_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && l_req) |=> !h_ack);
  assert_viol_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_viol |-> h_ack);
  assert_blocked_returns_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ack && h_viol) |-> (h_rdata == '1));
  assert_rdata_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_ack && $past(!h_ack)) |-> $stable(h_rdata));

endmodule

// File: tb/hostram_window_dec_tb.sv
module hostram_window_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0, cfg_rdata;
  logic        h_req = 0, h_io = 1, h_wr = 0;
  logic [11:0] h_addr = 0;
  logic [7:0]  h_wdata = 0, h_rdata;
  logic        h_ack, h_viol;
  logic        l_req = 0, l_wr = 0;
  logic [11:0] l_addr = 0;
  logic [7:0]  l_wdata = 0, l_rdata;

  hostram_window_dec u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [7:0] mm [4096];
  logic [7:0] m_ctrl, m_base [2], m_attr [2];
  logic       e_ack, e_viol;
  logic [7:0] e_hrd, e_lrd;
  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_base[0] = 0; m_base[1] = 0; m_attr[0] = 0; m_attr[1] = 0;
      e_ack = 0; e_viol = 0; e_hrd = 0; e_lrd = 0;
    end else begin
      bit g, blocked, up;
      int win, len, st, c;
      g = h_req && !l_req && !e_ack;
      win = -1; blocked = 0;
      for (int w = 1; w >= 0; w--) begin
        len = 16 << (m_attr[w] & 7);
        st  = ((int'(m_base[w]) * 16) / len) * len;
        if (m_ctrl[w] && (h_io == m_ctrl[4]) && int'(h_addr) >= st && int'(h_addr) < st + len) begin
          win = w;
          up  = (int'(h_addr) - st) >= len / 2;
          c   = h_wr ? int'(m_attr[w][5:4]) : int'(m_attr[w][7:6]);
          blocked = (c == 3) || (c == 1 && !up) || (c == 2 && up);
        end
      end
      e_ack  = g;
      e_viol = g && win >= 0 && blocked;
      if (g) e_hrd = (win >= 0 && !blocked && !h_wr) ? mm[h_addr] : 8'hFF;
      if (l_req && !l_wr) e_lrd = mm[l_addr];
      if (l_req && l_wr) mm[l_addr] = l_wdata;
      else if (g && win >= 0 && !blocked && h_wr) mm[h_addr] = h_wdata;
      if (cfg_we) case (cfg_addr)
        0: m_ctrl = cfg_wdata & 8'h13;
        1: m_base[0] = cfg_wdata;
        2: m_base[1] = cfg_wdata;
        3: m_attr[0] = cfg_wdata;
        4: m_attr[1] = cfg_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] exp_cfg(logic [2:0] a);
    case (a)
      0: return m_ctrl;
      1: return m_base[0];
      2: return m_base[1];
      3: return m_attr[0];
      4: return m_attr[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string nm, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("h_ack", {7'd0, h_ack}, {7'd0, e_ack});
      chk("h_viol", {7'd0, h_viol}, {7'd0, e_viol});
      chk("h_rdata", h_rdata, e_hrd);
      chk("l_rdata", l_rdata, e_lrd);
      chk("cfg_rdata", cfg_rdata, exp_cfg(cfg_addr));
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic cfg_w(logic [2:0] a, logic [7:0] d);
    tick(); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick(); cfg_we = 0;
  endtask

  task automatic lrd(logic [11:0] a);
    tick(); l_req = 1; l_wr = 0; l_addr = a;
    tick(); l_req = 0; tick();
  endtask

  task automatic hacc(logic io, logic wr, logic [11:0] a, logic [7:0] d);
    tick(); h_req = 1; h_io = io; h_wr = wr; h_addr = a; h_wdata = d;
    do @(negedge clk); while (!h_ack && cyc < 150000);
    #1 h_req = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin tick(); cfg_addr = 3'(a); end
    tick();

    cur_req = "R11";
    tick(); l_req = 1; l_wr = 1;
    for (int a = 0; a < 4096; a++) begin
      l_addr = 12'(a); l_wdata = 8'(a ^ (a >> 4) * 7);
      tick();
    end
    l_req = 0;
    lrd(12'h123); lrd(12'h900); lrd(12'hFFF);

    cur_req = "R2";
    cfg_w(0, 8'hFF); cfg_w(5, 8'hAA); cfg_w(6, 8'h55); cfg_w(7, 8'h11);
    for (int a = 0; a < 8; a++) begin tick(); cfg_addr = 3'(a); end
    cfg_w(0, 8'h13); cfg_w(1, 8'h80); cfg_w(3, 8'h04); cfg_w(2, 8'h90); cfg_w(4, 8'h34);
    for (int a = 0; a < 8; a++) begin tick(); cfg_addr = 3'(a); end

    cur_req = "R3";
    hacc(1, 0, 12'h800, 0); hacc(1, 0, 12'h8FF, 0); hacc(1, 0, 12'h900, 0); hacc(1, 0, 12'h9FF, 0);
    cur_req = "R4";
    hacc(1, 1, 12'h810, 8'h3C); hacc(1, 0, 12'h810, 0); lrd(12'h810);
    cur_req = "R7";
    hacc(1, 0, 12'h7FF, 0); hacc(1, 0, 12'hA00, 0); hacc(0, 0, 12'h820, 0);
    hacc(1, 1, 12'hA10, 8'h77); lrd(12'hA10);
    cur_req = "R6";
    hacc(1, 1, 12'h910, 8'hEE); lrd(12'h910); hacc(1, 0, 12'h910, 0);

    cur_req = "R5";
    for (int c = 0; c < 16; c++) begin
      cfg_w(4, 8'((c << 4) | 4));
      hacc(1, 0, 12'h904, 0); hacc(1, 0, 12'h9F4, 0);
      hacc(1, 1, 12'h904, 8'(c)); hacc(1, 1, 12'h9F4, 8'(c + 100));
      lrd(12'h904); lrd(12'h9F4);
    end
    cfg_w(4, 8'h34);

    cur_req = "R3";
    for (int s = 0; s < 8; s++) begin
      int len, st;
      cfg_w(3, 8'(s));
      cfg_w(1, 8'h85);
      len = 16 << s; st = (12'h850 / len) * len;
      if (st > 0) hacc(1, 0, 12'(st - 1), 0);
      hacc(1, 0, 12'(st), 0);
      hacc(1, 0, 12'(st + len - 1), 0);
      if (st + len < 4096) hacc(1, 0, 12'(st + len), 0);
    end
    cfg_w(0, 8'h03);
    hacc(0, 0, 12'h850, 0); hacc(1, 0, 12'h850, 0);

    cur_req = "R8";
    cfg_w(0, 8'h13); cfg_w(1, 8'h80); cfg_w(3, 8'h04);
    cfg_w(2, 8'h80); cfg_w(4, 8'hF4);
    hacc(1, 0, 12'h820, 0); hacc(1, 1, 12'h8C0, 8'h5A); lrd(12'h8C0);
    cfg_w(0, 8'h12);
    hacc(1, 0, 12'h820, 0); hacc(1, 1, 12'h8C1, 8'hA5); lrd(12'h8C1);

    cur_req = "R10";
    cfg_w(0, 8'h13);
    tick(); l_req = 1; l_wr = 0; l_addr = 12'h100;
    h_req = 1; h_io = 1; h_wr = 0; h_addr = 12'h830;
    tick(); l_addr = 12'h101; tick(); l_wr = 1; l_addr = 12'h830; l_wdata = 8'hC3; tick();
    l_req = 0;
    do @(negedge clk); while (!h_ack && cyc < 150000);
    #1 h_req = 0;

    cur_req = "R9";
    hacc(1, 0, 12'h831, 0); hacc(1, 0, 12'h832, 0);
    repeat (4) tick();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule